// File: doc/BRIEF.md
# Fuse-Policed Debug Unlock Gate

This block decides whether an external debugger may use the chip's debug logic. A 2-bit policy field from fuses selects one of four behaviours. Debug can be always allowed, or always refused. In the two remaining modes debug stays refused until the debugger proves knowledge of a 64-bit secret. In those modes the debugger reads a fuse-held challenge through a small register port and writes back a 64-bit response. The block compares that response with a fuse-held expected value.

In one of the challenge modes, a successful unlock goes through a fixed sequence before debug opens. The block first reports active debug to the security monitor. It then requests that ephemeral secrets be wiped and persistent ones be locked out. Wrong responses are counted. The third wrong response shuts the mechanism down until the next power-on reset and raises a violation toward the monitor. Boundary-scan interconnect testing is allowed in every mode.

Top module: `dbg_unlock_gate`

## Requirements
- R1: With `pol_mode` = 2'b00 (open) `dbg_en` is high after reset, and response writes change nothing and raise no pulse or violation.
- R2: With `pol_mode` = 2'b11 (locked) `dbg_en` stays low even after a correct response, and no pulse or violation is raised.
- R3: `bscan_en` is high in every mode, locked mode included.
- R4: On the register port, read address 0 returns challenge bits 31:0 and address 1 returns bits 63:32. Addresses 2 and 3 read as zero. A write to address 2 stores response bits 31:0. A write to address 3 supplies bits 63:32 and triggers evaluation of the full 64-bit response in that same cycle.
- R5: With `pol_mode` = 2'b01 (challenge, quiet) a correct response drives `dbg_en` high from the cycle after the triggering write, and raises neither `dbg_active_p` nor `secret_clr_p`.
- R6: With `pol_mode` = 2'b10 (challenge, notifying) a correct response gives this sequence. `dbg_active_p` is high for the one cycle after the triggering write. `secret_clr_p` is high for the next cycle. `dbg_en` rises in the cycle after that.
- R7: Once granted, `dbg_en` holds until reset. Later response writes, right or wrong, are not evaluated and raise no violation.
- R8: In a challenge mode, the first and second wrong responses leave `dbg_en` low and do not raise `sec_viol`. The third wrong response makes `sec_viol` high for exactly the one cycle after its triggering write.
- R9: After the third failure, no response is evaluated: a correct one leaves `dbg_en` low. Only reset clears the lockout and the failure count.
- R10: A response that differs from the expected value in any single bit, at either end of either half, counts as a failure.
- R11: `dbg_active_p`, `secret_clr_p` and `sec_viol` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pol_mode | input | 2 | Fuse policy: 00 open, 01 challenge quiet, 10 challenge notifying, 11 locked |
| fuse_chal | input | 64 | Fuse challenge value |
| fuse_resp | input | 64 | Fuse expected response |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dbg_en | output | 1 | Debug access enable, level |
| bscan_en | output | 1 | Boundary-scan enable |
| dbg_active_p | output | 1 | One-cycle pulse: debug becoming active |
| secret_clr_p | output | 1 | One-cycle pulse: wipe ephemeral, lock persistent secrets |
| sec_viol | output | 1 | One-cycle pulse: security violation |

## Verification
Read data is combinational, so it is checked in the same cycle as the address. All other results are measured from the clock edge that captures the write to address 3. `dbg_active_p`, `sec_viol` and the quiet-mode `dbg_en` are due one cycle later. `secret_clr_p` is due two cycles later, and the notifying-mode `dbg_en` three cycles later. The bench drives on falling edges and samples on the falling edge that follows each of those rising edges. The edges it counts are exactly those of the requirement.

// File: rtl/dbg_unlock_gate.sv
module dbg_unlock_gate #(
  parameter int KW        = 64,
  parameter int MAX_FAILS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pol_mode,
  input  logic [KW-1:0] fuse_chal,
  input  logic [KW-1:0] fuse_resp,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [KW/2-1:0] reg_wdata,
  output logic [KW/2-1:0] reg_rdata,
  output logic          dbg_en,
  output logic          bscan_en,
  output logic          dbg_active_p,
  output logic          secret_clr_p,
  output logic          sec_viol
);
  localparam int HW = KW / 2;
  localparam int CW = $clog2(MAX_FAILS + 1);

  typedef enum logic [2:0] {S_IDLE, S_NOTE, S_WIPE, S_GRANT, S_DEAD} st_t;

  st_t            st;
  logic [HW-1:0]  resp_lo;
  logic [CW-1:0]  fails;

  wire challenged = (pol_mode == 2'b01) || (pol_mode == 2'b10);
  wire submit     = reg_wr && (reg_addr == 2'd3) && challenged && (st == S_IDLE);
  wire match      = ({reg_wdata, resp_lo} == fuse_resp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fails    <= '0;
      resp_lo  <= '0;
      sec_viol <= 1'b0;
    end else begin
      sec_viol <= 1'b0;
      if (reg_wr && reg_addr == 2'd2) resp_lo <= reg_wdata;
      case (st)
        S_IDLE: if (submit) begin
          if (match) begin
            st <= (pol_mode == 2'b10) ? S_NOTE : S_GRANT;
          end else begin
            fails <= fails + CW'(1);
            if (fails == CW'(MAX_FAILS - 1)) begin
              st       <= S_DEAD;
              sec_viol <= 1'b1;
            end
          end
        end
        S_NOTE:  st <= S_WIPE;
        S_WIPE:  st <= S_GRANT;
        default: st <= st;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = fuse_chal[HW-1:0];
      2'd1:    reg_rdata = fuse_chal[KW-1:HW];
      default: reg_rdata = '0;
    endcase
  end

  assign dbg_en       = (pol_mode == 2'b00) || (st == S_GRANT);
  assign bscan_en     = 1'b1;
  assign dbg_active_p = (st == S_NOTE);
  assign secret_clr_p = (st == S_WIPE);
endmodule

// File: rtl/dbg_unlock_gate_chk.sv
module dbg_unlock_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pol_mode,
  input logic       dbg_en,
  input logic       dbg_active_p,
  input logic       secret_clr_p,
  input logic       sec_viol
);
  p_locked_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_mode == 2'b11) |-> !dbg_en && !dbg_active_p && !secret_clr_p && !sec_viol);

  p_quiet_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_mode == 2'b01) |-> !dbg_active_p && !secret_clr_p);

  p_note_then_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active_p |=> secret_clr_p && !dbg_en);

  p_wipe_then_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    secret_clr_p |=> dbg_en);

  p_enable_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en |=> dbg_en || (pol_mode != $past(pol_mode)));

  p_viol_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_viol |=> !sec_viol);

  p_note_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active_p |=> !dbg_active_p);

  p_viol_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_viol |-> !dbg_en);
endmodule

bind dbg_unlock_gate dbg_unlock_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pol_mode(pol_mode), .dbg_en(dbg_en),
  .dbg_active_p(dbg_active_p), .secret_clr_p(secret_clr_p), .sec_viol(sec_viol)
);

// File: tb/tb_dbg_unlock_gate.sv
module tb_dbg_unlock_gate;
  localparam int PERIOD = 10;
  localparam logic [63:0] CHAL = 64'hC3A5_1E0F_7B29_D468;
  localparam logic [63:0] RESP = 64'h5EED_F00D_0BAD_CAFE;

  typedef struct packed {
    logic [1:0]  mode;
    logic [63:0] flip;
    logic        en;
    logic        note;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 64'h0,                   1'b1, 1'b0},
    '{2'b00, 64'h1,                   1'b1, 1'b0},
    '{2'b01, 64'h0,                   1'b1, 1'b0},
    '{2'b01, 64'h1,                   1'b0, 1'b0},
    '{2'b01, 64'h8000_0000_0000_0000, 1'b0, 1'b0},
    '{2'b10, 64'h0,                   1'b1, 1'b1},
    '{2'b10, 64'h0000_0000_8000_0000, 1'b0, 1'b0},
    '{2'b10, 64'h0000_0001_0000_0000, 1'b0, 1'b0},
    '{2'b11, 64'h0,                   1'b0, 1'b0},
    '{2'b11, 64'h4,                   1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pol_mode = 2'b01;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_en, bscan_en, dbg_active_p, secret_clr_p, sec_viol;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  dbg_unlock_gate dut (
    .clk(clk), .rst_n(rst_n), .pol_mode(pol_mode), .fuse_chal(CHAL), .fuse_resp(RESP),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dbg_en(dbg_en), .bscan_en(bscan_en), .dbg_active_p(dbg_active_p),
    .secret_clr_p(secret_clr_p), .sec_viol(sec_viol)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; pol_mode = m; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic send(input logic [63:0] v);
    wr(2'd2, v[31:0]);
    wr(2'd3, v[63:32]);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset(2'b01);
    chk("R5 reset dbg_en", {63'd0, dbg_en}, 64'd0);
    chk("R11 reset pulses", {61'd0, dbg_active_p, secret_clr_p, sec_viol}, 64'd0);
    reg_addr = 2'd0; #1 chk("R4 chal lo", {32'd0, reg_rdata}, {32'd0, CHAL[31:0]});
    reg_addr = 2'd1; #1 chk("R4 chal hi", {32'd0, reg_rdata}, {32'd0, CHAL[63:32]});
    reg_addr = 2'd3; #1 chk("R4 addr3 zero", {32'd0, reg_rdata}, 64'd0);
    reg_addr = 2'd0;

    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].mode);
      chk("R3 bscan", {63'd0, bscan_en}, 64'd1);
      send(RESP ^ VECS[i].flip);
      chk("R6/R5 note pulse", {63'd0, dbg_active_p}, {63'd0, VECS[i].note});
      chk("R8 no early viol", {63'd0, sec_viol}, 64'd0);
      if (VECS[i].mode == 2'b01)
        chk("R5 en next cycle", {63'd0, dbg_en}, {63'd0, VECS[i].en});
      @(negedge clk);
      chk("R6 clr pulse", {63'd0, secret_clr_p}, {63'd0, VECS[i].note});
      if (VECS[i].note) chk("R6 en after clr", {63'd0, dbg_en}, 64'd0);
      @(negedge clk);
      chk("R1/R2/R10 final en", {63'd0, dbg_en}, {63'd0, VECS[i].en});
      chk("R11 clr ended", {63'd0, secret_clr_p}, 64'd0);
    end

    do_reset(2'b01);
    send(~RESP);
    send(RESP ^ 64'h2);
    chk("R8 two fails no viol", {62'd0, sec_viol, dbg_en}, 64'd0);
    send(RESP ^ 64'h10);
    chk("R8 third fail viol", {63'd0, sec_viol}, 64'd1);
    @(negedge clk);
    chk("R11 viol single", {63'd0, sec_viol}, 64'd0);
    send(RESP);
    repeat (2) @(negedge clk);
    chk("R9 locked out", {63'd0, dbg_en}, 64'd0);
    do_reset(2'b01);
    send(~RESP); send(~RESP);
    send(RESP);
    chk("R9 reset clears count", {62'd0, sec_viol, dbg_en}, 64'd1);

    send(~RESP); send(~RESP); send(~RESP);
    chk("R7 no viol after grant", {63'd0, sec_viol}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R7 en holds", {63'd0, dbg_en}, 64'd1);

    do_reset(2'b00);
    send(~RESP); send(~RESP); send(~RESP);
    chk("R1 open ignores writes", {62'd0, sec_viol, dbg_en}, 64'd1);

    do_reset(2'b10);
    send(RESP ^ 64'h1); send(RESP ^ 64'h1);
    send(RESP ^ 64'h1);
    chk("R8 notify third fail", {63'd0, sec_viol}, 64'd1);
    send(RESP);
    chk("R9 no note after lockout", {63'd0, dbg_active_p}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule